// File: doc/BRIEF.md
# Bus State Capture Buffer

This block is a synchronous state-mode recorder for a parallel bus. On every bus clock edge it stores a 48-bit snapshot of the bus lines into an on-chip ring memory. A pulse on the arm input starts a capture. From then on, snapshots are written continuously around the ring until the trigger input is seen. From the trigger on, the block records just enough further snapshots to fill the memory, keeping a chosen number of samples from before the trigger. It then stops and raises a done flag.

After capture, a host reads the record one byte at a time through a synchronous read port on its own clock. Each stored sample spans eight consecutive host byte addresses: six bytes of bus data followed by two fixed padding bytes. Host sample index 0 is always the oldest kept sample, so the host never needs to know where the ring pointer stopped. Pre-trigger slots that were never filled in the current capture read back as zero, so stale data from an earlier capture cannot appear.

Top module: `bus_cap_top`

## Requirements
- R1: A sample is the value of `smp_i` at a bus clock edge. Bits 47:16 carry the 32-bit address/data lines, bits 15:12 the command/byte-enable lines, and bits 11:0 carry the control lines in this order from bit 11 down to bit 0: IRDY#, TRDY#, FRAME#, DEVSEL#, IDSEL, PAR, GNT#, LOCK#, PERR#, REQ#, SERR#, STOP#. Host byte address `rd_addr_i` = {sample index, byte}, where bits 2:0 select the byte. Byte b (0..5) returns sample bits 8b+7:8b.
- R2: Byte 6 of every sample reads 0x01 and byte 7 reads 0x02, including samples that read as zero.
- R3: A cycle with `arm_i` high clears `done_o` at that edge, resets the write position, and latches `pre_cnt_i`. The first sample is taken at the following edge. `trig_i` has no effect unless a capture is armed and not yet done.
- R4: While armed and before the trigger, one sample is written per bus clock, wrapping around the DEPTH-entry ring without stopping.
- R5: The sample at the edge where `trig_i` is first seen high is the trigger sample. Counting it, exactly DEPTH − pre further samples are written. `done_o` rises at the edge that writes the last of them.
- R6: Host sample index i returns the sample taken pre − i clocks before the trigger sample when i < pre, and the sample taken i − pre clocks after it otherwise. Index pre is the trigger sample.
- R7: If fewer than pre samples were taken before the trigger, the host indices that have no sample in the current capture return zero in bytes 0..5.
- R8: After `done_o` rises, no sample is written, `done_o` stays high and `trig_i` is ignored until the next arm.
- R9: Read data appears on `rd_data_o` two host clock edges after `rd_addr_i` is applied. Host reads never change what is captured.
- R10: The pre-trigger count used by a capture is the value of `pre_cnt_i` at arm time. Later changes to the input do not affect it.
- R11: Arming while a capture is in progress abandons that capture and starts a new one from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_i | input | 48 | Bus snapshot vector |
| arm_i | input | 1 | Start a new capture (one bus clock pulse) |
| trig_i | input | 1 | Trigger condition |
| pre_cnt_i | input | AW | Pre-trigger samples to keep, 0..DEPTH-1 |
| done_o | output | 1 | Capture complete |
| host_clk_i | input | 1 | Host read clock |
| rd_addr_i | input | AW+3 | Host byte address {sample index, byte} |
| rd_data_o | output | 8 | Host read byte |

## Verification
The hardest case to reach is a trigger that arrives before the ring holds pre samples. In that case the oldest host indices point at ring slots whose contents come from the previous capture, and those slots must read as zero. The bench runs back-to-back captures on a 16-entry ring and sweeps every pre-trigger count against trigger delays both shorter than and beyond one full ring lap. Every capture leaves distinct non-zero data behind, so stale slots are always populated. Each sweep also includes an aborted capture with a re-arm, and stale-data checks against it.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_PRE,
    CAP_POST,
    CAP_DONE
  } cap_state_e;

  localparam int unsigned BYTES_PER_SLOT = 8;

  function automatic logic [7:0] pad_byte(input int unsigned idx);
    case (idx)
      6:       return 8'h01;
      7:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic [AW-1:0] pre_cnt_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] miss_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    state_q;
  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] pre_q;
  logic [AW-1:0] fill_q;     // samples before trigger, saturating
  logic [AW-1:0] left_q;     // post-trigger samples still to write
  logic [AW-1:0] base_q;
  logic [AW-1:0] miss_q;
  logic          done_q;

  assign we_o    = !arm_i && (state_q == CAP_PRE || state_q == CAP_POST);
  assign waddr_o = wr_ptr_q;
  assign base_o  = base_q;
  assign miss_o  = miss_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAP_IDLE;
      wr_ptr_q <= '0;
      pre_q    <= '0;
      fill_q   <= '0;
      left_q   <= '0;
      base_q   <= '0;
      miss_q   <= '0;
      done_q   <= 1'b0;
    end else if (arm_i) begin
      state_q  <= CAP_PRE;
      wr_ptr_q <= '0;
      pre_q    <= pre_cnt_i;
      fill_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        CAP_PRE: begin
          wr_ptr_q <= wr_ptr_q + AW'(1);
          if (trig_i) begin
            base_q <= wr_ptr_q - pre_q;
            miss_q <= (pre_q > fill_q) ? pre_q - fill_q : '0;
            left_q <= LAST - pre_q;
            if (pre_q == LAST) begin
              state_q <= CAP_DONE;
              done_q  <= 1'b1;
            end else begin
              state_q <= CAP_POST;
            end
          end else if (fill_q != LAST) begin
            fill_q <= fill_q + AW'(1);
          end
        end
        CAP_POST: begin
          wr_ptr_q <= wr_ptr_q + AW'(1);
          left_q   <= left_q - AW'(1);
          if (left_q == AW'(1)) begin
            state_q <= CAP_DONE;
            done_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int unsigned WIDTH = 48,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cap_rdout.sv
module cap_rdout
  import cap_pkg::*;
#(
  parameter int unsigned SMP_W = 48,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned NB = SMP_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW+2:0]    rd_addr_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    miss_i,
  output logic [AW-1:0]    raddr_o,
  input  logic [SMP_W-1:0] rdata_i,
  output logic [7:0]       rd_data_o
);
  logic [AW-1:0] idx;
  logic          zero_q;
  logic [2:0]    bsel_q;
  logic [7:0]    lane [BYTES_PER_SLOT];

  assign idx     = rd_addr_i[AW+2:3];
  assign raddr_o = base_i + idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b0;
      bsel_q <= '0;
    end else begin
      zero_q <= idx < miss_i;
      bsel_q <= rd_addr_i[2:0];
    end
  end

  for (genvar b = 0; b < BYTES_PER_SLOT; b++) begin : g_lane
    if (b < NB) begin : g_data
      assign lane[b] = zero_q ? 8'h00 : rdata_i[8*b +: 8];
    end else begin : g_pad
      assign lane[b] = pad_byte(b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= lane[bsel_q];
  end
endmodule

// File: rtl/bus_cap_top.sv
module bus_cap_top #(
  parameter int unsigned SMP_W = 48,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             bus_clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic [AW-1:0]    pre_cnt_i,
  output logic             done_o,
  input  logic             host_clk_i,
  input  logic [AW+2:0]    rd_addr_i,
  output logic [7:0]       rd_data_o
);
  logic             wr_we;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    base;
  logic [AW-1:0]    miss;
  logic [AW-1:0]    rd_maddr;
  logic [SMP_W-1:0] rd_word;

  cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (bus_clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .trig_i   (trig_i),
    .pre_cnt_i(pre_cnt_i),
    .we_o     (wr_we),
    .waddr_o  (wr_addr),
    .base_o   (base),
    .miss_o   (miss),
    .done_o   (done_o)
  );

  cap_mem #(.WIDTH(SMP_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i (bus_clk_i),
    .we_i   (wr_we),
    .waddr_i(wr_addr),
    .wdata_i(smp_i),
    .rclk_i (host_clk_i),
    .raddr_i(rd_maddr),
    .rdata_o(rd_word)
  );

  cap_rdout #(.SMP_W(SMP_W), .DEPTH(DEPTH)) u_rdout (
    .clk_i    (host_clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(rd_addr_i),
    .base_i   (base),
    .miss_i   (miss),
    .raddr_o  (rd_maddr),
    .rdata_i  (rd_word),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/bus_cap_chk.sv
module bus_cap_chk #(
  parameter int unsigned AW = 8
) (
  input logic          bus_clk_i,
  input logic          host_clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          done_o,
  input logic          wr_we,
  input logic [AW-1:0] wr_addr,
  input logic [AW+2:0] rd_addr_i,
  input logic [7:0]    rd_data_o
);
  logic       armed_q;
  logic [1:0] hcnt_q;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  always_ff @(posedge host_clk_i or negedge rst_ni) begin
    if (!rst_ni)              hcnt_q <= '0;
    else if (hcnt_q != 2'd3) hcnt_q <= hcnt_q + 2'd1;
  end

  a_r3_arm_restarts: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    arm_i |=> !done_o && wr_addr == '0);

  a_r3_no_done_unarmed: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !armed_q && !arm_i |=> !done_o);

  a_r4_ptr_steps: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    wr_we |=> wr_addr == $past(wr_addr) + AW'(1));

  a_r5_done_on_write: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_we));

  a_r8_done_frozen: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    done_o && !arm_i |=> done_o && $stable(wr_addr));

  a_r2_pad_six: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
    hcnt_q == 2'd3 && $past(rd_addr_i[2:0], 2) == 3'd6 |-> rd_data_o == 8'h01);

  a_r2_pad_seven: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
    hcnt_q == 2'd3 && $past(rd_addr_i[2:0], 2) == 3'd7 |-> rd_data_o == 8'h02);
endmodule

bind bus_cap_top bus_cap_chk #(.AW(AW)) u_chk (
  .bus_clk_i (bus_clk_i),
  .host_clk_i(host_clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .done_o    (done_o),
  .wr_we     (wr_we),
  .wr_addr   (wr_addr),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/tb_bus_cap_top.sv
module tb_bus_cap_top;
  localparam int D  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [47:0]   smp_i = '0;
  logic          arm_i = 1'b0;
  logic          trig_i = 1'b0;
  logic [AW-1:0] pre_cnt_i = '0;
  logic          done_o;
  logic [AW+2:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  bus_cap_top #(.SMP_W(48), .DEPTH(D)) dut (
    .bus_clk_i (clk),
    .rst_ni    (rst_ni),
    .smp_i     (smp_i),
    .arm_i     (arm_i),
    .trig_i    (trig_i),
    .pre_cnt_i (pre_cnt_i),
    .done_o    (done_o),
    .host_clk_i(clk),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  function automatic logic [47:0] pat(int run, int k);
    logic [31:0] a;
    logic [15:0] c;
    a = (32'(run) * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0001;
    c = 16'(k * 945 + run * 7 + 1);
    return {a, c};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Arm and drive k = 0..n-1 with trigger at trig_at; pre_cnt_i scrambled after arm (R10).
  task automatic arm_and_drive(int run, int pre, int trig_at, int n);
    pre_cnt_i = AW'(pre);
    arm_i = 1'b1;
    trig_i = 1'b0;
    step();
    arm_i = 1'b0;
    pre_cnt_i = ~AW'(pre);
    for (int k = 0; k < n; k++) begin
      smp_i = pat(run, k);
      trig_i = (k == trig_at);
      rd_addr_i = (AW + 3)'(k * 5);          // host traffic during capture (R9)
      if (k == n - 1 && n == trig_at + D - pre)
        chk({31'd0, done_o}, 32'd0, "R5 done early");
      step();
    end
    trig_i = 1'b0;
  endtask

  task automatic do_run(int run, int pre, int trig_at, string rtag);
    int total;
    total = trig_at + D - pre;
    arm_and_drive(run, pre, trig_at, total);
    chk({31'd0, done_o}, 32'd1, "R5 done at last write");
    // After done: more samples and a trigger pulse must change nothing (R8)
    for (int j = 0; j < 4; j++) begin
      smp_i = ~pat(run, total + j);
      trig_i = (j == 1);
      step();
    end
    trig_i = 1'b0;
    chk({31'd0, done_o}, 32'd1, "R8 done holds");
    for (int i = 0; i < D; i++) begin
      for (int b = 0; b < 8; b++) begin
        int kk;
        logic [7:0] exp;
        string btag;
        kk = trig_at - pre + i;
        if (b == 6) begin exp = 8'h01; btag = "R2"; end
        else if (b == 7) begin exp = 8'h02; btag = "R2"; end
        else if (kk < 0) begin exp = 8'h00; btag = "R7"; end
        else begin
          logic [47:0] s;
          s = pat(run, kk);
          exp = s[8*b +: 8];
          btag = (i == pre) ? "R6" : (trig_at >= D ? "R4" : "R1");
        end
        rd_addr_i = {AW'(i), 3'(b)};
        @(posedge clk);
        step();                              // two host edges (R9)
        chk({24'd0, rd_data_o}, {24'd0, exp},
            $sformatf("%s/%s run=%0d pre=%0d trig=%0d idx=%0d byte=%0d",
                      rtag, btag, run, pre, trig_at, i, b));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int run;
    int trigs[6] = '{0, 2, 7, 15, 16, 21};
    repeat (3) @(negedge clk);
    chk({31'd0, done_o}, 32'd0, "R3 reset done");
    chk({24'd0, rd_data_o}, 32'd0, "R9 reset data");
    rst_ni = 1'b1;
    step();
    // Trigger before any arm is ignored (R3)
    for (int k = 0; k < 6; k++) begin
      smp_i = pat(99, k);
      trig_i = 1'b1;
      step();
    end
    trig_i = 1'b0;
    chk({31'd0, done_o}, 32'd0, "R3 unarmed trigger ignored");
    run = 0;
    for (int p = 0; p < D; p++) begin
      foreach (trigs[t]) begin
        do_run(run, p, trigs[t], "R5");
        run++;
      end
      // Re-arm mid-capture, then a short-history capture (R11, R3)
      arm_and_drive(run, 3, 1, 5);
      run++;
      chk({31'd0, done_o}, 32'd0, "R11 aborted capture not done");
      do_run(run, p, p / 2, "R11");
      run++;
    end
    // Re-arm clears done (R3)
    arm_i = 1'b1;
    step();
    arm_i = 1'b0;
    chk({31'd0, done_o}, 32'd0, "R3 arm clears done");
    finish_up();
  end
endmodule